// File: doc/BRIEF.md
# Digital Phase Lock Detector

This block decides whether a phase-locked loop has settled. It watches the UP and DOWN pulses of a phase-frequency detector. In each phase detector cycle it measures how long either pulse is active, counted in periods of a fast timing clock. It then classifies that error as small, medium or large against two programmable thresholds. The thresholds are expressed in timing-clock counts. With a 200 MHz timing clock, the defaults of 3 and 5 counts correspond to 15 ns and 25 ns.

A strobe marks the end of each phase detector cycle. The lock flag rises once a chosen number of consecutive cycles have all shown a small error. A select bit picks a run of three or five cycles. Once raised, the flag ignores medium errors and falls on the first cycle that shows a large error. This gap between the two thresholds is the hysteresis of the block.

Top module: `phase_lock_detect`

## Requirements
- R1: A synchronous reset drives lock_o low and clears the run counter. The first pd_strobe_i after reset only opens a measurement window and is never judged.
- R2: With run_sel_i at 0, lock_o rises after three consecutive judged cycles whose error is below LOCK_LIMIT (default 3 counts).
- R3: With run_sel_i at 1, five consecutive small-error cycles are needed before lock_o rises; four are not enough.
- R4: While locked, a single cycle whose error is strictly greater than UNLOCK_LIMIT (default 5 counts) drops lock_o.
- R5: While locked, a cycle whose error is at least LOCK_LIMIT and at most UNLOCK_LIMIT leaves lock_o high.
- R6: While unlocked, a cycle whose error is at or above LOCK_LIMIT clears the run of small cycles, so a full new run is needed. An error equal to LOCK_LIMIT counts as not small.
- R7: run_sel_i is sampled when each cycle is judged. Changing it mid-run applies to that judgement, and the run counter saturates at the run length and never exceeds five.
- R8: The error of a cycle is the number of timing-clock cycles, between one strobe and the next, in which up_i or dn_i (or both) is high. Overlapping UP and DOWN activity is counted once, and DOWN alone counts the same as UP alone.
- R9: A change of lock_o becomes visible on the second rising clk_i edge that follows the edge sampling pd_strobe_i, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast timing clock used to measure pulse widths |
| rst_i | input | 1 | Synchronous active-high reset |
| up_i | input | 1 | UP pulse from the phase-frequency detector |
| dn_i | input | 1 | DOWN pulse from the phase-frequency detector |
| pd_strobe_i | input | 1 | One-clock strobe that closes the current phase detector cycle |
| run_sel_i | input | 1 | Run length select: 0 for three cycles, 1 for five |
| lock_o | output | 1 | Active-high lock flag |

## Verification
The detector is driven with runs of narrow UP pulses to reach lock under both run lengths. The run is then broken one cycle short, which shows that the run length is actually counted. Errors exactly at each threshold separate strict from non-strict comparisons, and medium errors while locked confirm the hysteresis. DOWN-only pulses and overlapping UP/DOWN pulses show that the error is the width of the union and not a sum. A run-length switch mid-run and a reset followed by unprimed strobes cover select sampling and discarding of the first window. A behavioural model compared on every clock also pins the two-edge latency.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

    // Classification of one phase detector cycle's error.
    typedef enum logic [1:0] {
        ERR_SMALL = 2'd0,
        ERR_MID   = 2'd1,
        ERR_LARGE = 2'd2
    } err_class_e;

    // Verdict handed from the classifier to the run tracker.
    typedef struct packed {
        logic       valid;
        err_class_e cls;
    } verdict_t;

    // Small: below lock limit. Large: strictly above unlock limit.
    function automatic err_class_e classify_err(
        input int unsigned width,
        input int unsigned lock_lim,
        input int unsigned unlock_lim
    );
        if (width < lock_lim)
            return ERR_SMALL;
        else if (width > unlock_lim)
            return ERR_LARGE;
        else
            return ERR_MID;
    endfunction

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pd_width_meter.sv
module pd_width_meter #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             up_i,
    input  logic             dn_i,
    input  logic             pd_strobe_i,
    output logic             meas_valid_o,
    output logic [CNT_W-1:0] meas_width_o
);
    logic             active;
    logic             primed_q;
    logic [CNT_W-1:0] acc_q;

    assign active = up_i | dn_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            acc_q        <= '0;
            primed_q     <= 1'b0;
            meas_valid_o <= 1'b0;
            meas_width_o <= '0;
        end else begin
            meas_valid_o <= pd_strobe_i & primed_q;
            if (pd_strobe_i) begin
                meas_width_o <= acc_q;
                primed_q     <= 1'b1;
                acc_q        <= {{(CNT_W-1){1'b0}}, active};
            end else if (active && (acc_q != {CNT_W{1'b1}})) begin
                acc_q <= acc_q + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/pd_error_classifier.sv
module pd_error_classifier
    import lockdet_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int LOCK_LIMIT   = 3,
    parameter int UNLOCK_LIMIT = 5
) (
    input  logic             meas_valid_i,
    input  logic [CNT_W-1:0] meas_width_i,
    output verdict_t         verdict_o
);
    always_comb begin
        verdict_o.valid = meas_valid_i;
        verdict_o.cls   = classify_err(int'(unsigned'(meas_width_i)),
                                       LOCK_LIMIT, UNLOCK_LIMIT);
    end
endmodule

// File: rtl/lock_run_tracker.sv
module lock_run_tracker
    import lockdet_pkg::*;
#(
    parameter int RUN_SHORT = 3,
    parameter int RUN_LONG  = 5,
    localparam int RUN_W    = $clog2(max_of(RUN_SHORT, RUN_LONG) + 1)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  verdict_t         verdict_i,
    input  logic             run_sel_i,
    output logic             lock_o,
    output logic [RUN_W-1:0] run_cnt_o
);
    logic [RUN_W-1:0] need;
    logic [RUN_W:0]   bumped;

    assign need   = run_sel_i ? RUN_W'(RUN_LONG) : RUN_W'(RUN_SHORT);
    assign bumped = {1'b0, run_cnt_o} + (RUN_W+1)'(1);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            lock_o    <= 1'b0;
            run_cnt_o <= '0;
        end else if (verdict_i.valid) begin
            if (!lock_o) begin
                if (verdict_i.cls == ERR_SMALL) begin
                    if (bumped >= {1'b0, need}) begin
                        run_cnt_o <= need;
                        lock_o    <= 1'b1;
                    end else begin
                        run_cnt_o <= bumped[RUN_W-1:0];
                    end
                end else begin
                    run_cnt_o <= '0;
                end
            end else if (verdict_i.cls == ERR_LARGE) begin
                lock_o    <= 1'b0;
                run_cnt_o <= '0;
            end
        end
    end
endmodule

// File: rtl/phase_lock_detect.sv
module phase_lock_detect
    import lockdet_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int LOCK_LIMIT   = 3,
    parameter int UNLOCK_LIMIT = 5,
    parameter int RUN_SHORT    = 3,
    parameter int RUN_LONG     = 5,
    localparam int RUN_W       = $clog2(max_of(RUN_SHORT, RUN_LONG) + 1)
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic up_i,
    input  logic dn_i,
    input  logic pd_strobe_i,
    input  logic run_sel_i,
    output logic lock_o
);
    logic             meas_valid;
    logic [CNT_W-1:0] meas_width;
    verdict_t         verdict;
    logic [RUN_W-1:0] run_cnt;

    pd_width_meter #(.CNT_W(CNT_W)) u_meter (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .up_i         (up_i),
        .dn_i         (dn_i),
        .pd_strobe_i  (pd_strobe_i),
        .meas_valid_o (meas_valid),
        .meas_width_o (meas_width)
    );

    pd_error_classifier #(
        .CNT_W        (CNT_W),
        .LOCK_LIMIT   (LOCK_LIMIT),
        .UNLOCK_LIMIT (UNLOCK_LIMIT)
    ) u_class (
        .meas_valid_i (meas_valid),
        .meas_width_i (meas_width),
        .verdict_o    (verdict)
    );

    lock_run_tracker #(
        .RUN_SHORT (RUN_SHORT),
        .RUN_LONG  (RUN_LONG)
    ) u_track (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .verdict_i (verdict),
        .run_sel_i (run_sel_i),
        .lock_o    (lock_o),
        .run_cnt_o (run_cnt)
    );
endmodule

// File: rtl/lockdet_chk.sv
module lockdet_chk #(
    parameter int CNT_W        = 8,
    parameter int LOCK_LIMIT   = 3,
    parameter int UNLOCK_LIMIT = 5,
    parameter int RUN_LONG     = 5,
    parameter int RUN_W        = 3
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             lock_o,
    input logic             meas_valid,
    input logic [CNT_W-1:0] meas_width,
    input logic [RUN_W-1:0] run_cnt
);
    // R1
    reset_clear_chk: assert property (@(posedge clk_i)
        rst_i |=> (!lock_o && run_cnt == '0));

    // R2
    lock_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(lock_o) |-> $past(meas_valid && (int'(meas_width) < LOCK_LIMIT)));

    // R4
    lock_fall_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(lock_o) |-> $past(meas_valid && (int'(meas_width) > UNLOCK_LIMIT)));

    // R5
    hold_mid_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (lock_o && meas_valid && (int'(meas_width) <= UNLOCK_LIMIT)) |=> lock_o);

    // R7
    run_sat_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        int'(run_cnt) <= RUN_LONG);

    // R9
    quiet_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !meas_valid |=> $stable(lock_o));
endmodule

bind phase_lock_detect lockdet_chk #(
    .CNT_W        (CNT_W),
    .LOCK_LIMIT   (LOCK_LIMIT),
    .UNLOCK_LIMIT (UNLOCK_LIMIT),
    .RUN_LONG     (RUN_LONG),
    .RUN_W        (RUN_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .lock_o     (lock_o),
    .meas_valid (meas_valid),
    .meas_width (meas_width),
    .run_cnt    (run_cnt)
);

// File: tb/sim_phase_lock_detect.sv
`timescale 1ns/1ps
module sim_phase_lock_detect;
    localparam int LOCK_LIM   = 3;
    localparam int UNLOCK_LIM = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic up = 1'b0, dn = 1'b0, strobe = 1'b0, sel = 1'b0;
    logic lock;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    phase_lock_detect u0 (
        .clk_i(clk), .rst_i(rst), .up_i(up), .dn_i(dn),
        .pd_strobe_i(strobe), .run_sel_i(sel), .lock_o(lock)
    );

    // Behavioural reference model, updated at each rising edge.
    int m_acc = 0, m_pw = 0, m_cnt = 0;
    bit m_primed = 0, m_pv = 0, m_lk = 0;

    always @(posedge clk) begin
        int need;
        if (rst) begin
            m_acc = 0; m_pw = 0; m_cnt = 0;
            m_primed = 0; m_pv = 0; m_lk = 0;
        end else begin
            if (m_pv) begin
                need = sel ? 5 : 3;
                if (!m_lk) begin
                    if (m_pw < LOCK_LIM) begin
                        m_cnt = m_cnt + 1;
                        if (m_cnt >= need) begin
                            m_cnt = need;
                            m_lk  = 1;
                        end
                    end else begin
                        m_cnt = 0;
                    end
                end else if (m_pw > UNLOCK_LIM) begin
                    m_lk  = 0;
                    m_cnt = 0;
                end
            end
            m_pv = 0;
            if (strobe) begin
                if (m_primed) begin
                    m_pv = 1;
                    m_pw = m_acc;
                end
                m_primed = 1;
                m_acc = (up || dn) ? 1 : 0;
            end else if ((up || dn) && m_acc < 255) begin
                m_acc = m_acc + 1;
            end
        end
    end

    // Per-clock comparison against the model (R9 latency, all behaviour)
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (lock !== m_lk) begin
                fails++;
                $display("FAIL R9 model compare t=%0t actual=%b expected=%b", $time, lock, m_lk);
            end
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // One PD cycle: UP for u cycles and DOWN for d cycles, both starting together,
    // then the closing strobe. chk>=0 also checks the two-edge latency.
    task automatic pd_cycle(input int u, input int d, input int chk);
        logic prev;
        int n = (u > d) ? u : d;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); up = (i < u); dn = (i < d);
        end
        @(negedge clk); up = 0; dn = 0;
        @(negedge clk);
        @(negedge clk); strobe = 1; prev = lock;
        @(negedge clk); strobe = 0;
        if (chk >= 0) check("R9 unchanged one edge after strobe", lock, prev);
        @(negedge clk);
        if (chk >= 0) check("R9 updated two edges after strobe", lock, chk[0]);
        @(negedge clk);
    endtask

    task automatic prime();
        @(negedge clk); strobe = 1;
        @(negedge clk); strobe = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        @(negedge clk);
        @(negedge clk); rst = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset state", lock, 1'b0);
        rst = 0;
        prime();

        // R2: three small cycles with sel=0
        sel = 0;
        pd_cycle(1, 0, -1);
        pd_cycle(2, 0, -1);
        check("R2 two small cycles not enough", lock, 1'b0);
        pd_cycle(0, 0, 1);
        check("R2 lock after three small cycles", lock, 1'b1);

        // R5: medium errors keep lock
        pd_cycle(4, 0, -1);
        check("R5 error 4 keeps lock", lock, 1'b1);
        pd_cycle(5, 0, -1);
        check("R5 error equal to unlock limit keeps lock", lock, 1'b1);

        // R4: error above unlock limit drops lock
        pd_cycle(6, 0, 0);
        check("R4 error 6 drops lock", lock, 1'b0);

        // R6: run broken by error equal to lock limit
        pd_cycle(2, 0, -1);
        pd_cycle(2, 0, -1);
        pd_cycle(3, 0, -1);
        pd_cycle(1, 0, -1);
        pd_cycle(1, 0, -1);
        check("R6 run restarted after boundary error", lock, 1'b0);
        pd_cycle(1, 0, -1);
        check("R6 lock after fresh run of three", lock, 1'b1);

        // R8: overlapping pulses counted once (union 4, sum 8)
        pd_cycle(4, 4, -1);
        check("R8 overlap counted once keeps lock", lock, 1'b1);
        // R8: DOWN alone counts the same as UP
        pd_cycle(0, 7, -1);
        check("R8 DOWN pulse width drops lock", lock, 1'b0);

        // R3: five needed with sel=1
        sel = 1;
        for (int k = 0; k < 4; k++) pd_cycle(0, 1, -1);
        check("R3 four small cycles not enough", lock, 1'b0);
        pd_cycle(1, 0, 1);
        check("R3 lock after five small cycles", lock, 1'b1);
        pd_cycle(9, 0, -1);
        check("R4 error 9 drops lock", lock, 1'b0);

        // R7: select changed mid-run
        sel = 1;
        for (int k = 0; k < 4; k++) pd_cycle(1, 0, -1);
        check("R7 no lock after four with sel=1", lock, 1'b0);
        sel = 0;
        pd_cycle(1, 0, 1);
        check("R7 lock once select drops to three", lock, 1'b1);

        // R1: reset mid-lock, then first window discarded
        do_reset();
        check("R1 reset clears lock", lock, 1'b0);
        sel = 0;
        pd_cycle(0, 0, -1);
        pd_cycle(0, 0, -1);
        pd_cycle(0, 0, -1);
        check("R1 first strobe after reset not judged", lock, 1'b0);
        pd_cycle(0, 0, 1);
        check("R1 lock after three judged cycles", lock, 1'b1);

        repeat (3) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule